// File: doc/BRIEF.md
# Receive Frame Buffer Packer

This block takes one received Ethernet frame, presented as a byte stream whose total length is known when the first byte arrives. It lays the frame out in a single page of packet RAM in the controller's receive-buffer format. That format has four parts:

- a 16-bit status word;
- a 16-bit byte count;
- the frame data, zero-padded when the frame is short;
- an optional CRC32 and a closing 16-bit control word.

The page number comes from an external allocator. Once the image is complete, a one-cycle push pulse hands the page to the receive queue, and the same pulse raises the receive interrupt.

Two configuration inputs are sampled together with the first byte: receive enable (with a soft-reset override) and CRC stripping. They decide whether the frame is stored at all and whether four CRC bytes are kept. The CRC32 is computed inside the block, one byte per clock. While the packer writes its trailer and header bytes it deasserts `s_ready`. The header goes in last, because the byte count and the odd flag describe the whole frame.

Top module: `rx_frame_packer`

## Requirements
- R1: A frame whose first byte arrives while `rx_en` is 0 or `soft_rst` is 1 is dropped. No RAM write and no push occur, and `s_ready` stays 1 so the stream is still consumed.
- R2: The byte count has three terms, and exactly that many RAM writes happen for a stored frame:
  - base: 64 when L < 64, otherwise L rounded down to even;
  - plus 6;
  - plus 4 more when `crc_strip` is 0.
- R3: A frame whose byte count would exceed 2048 is dropped, with no writes and no push.
- R4: Page bytes 0 and 1 hold the status word, little-endian:
  - bit 11 is set when L > 1518;
  - bit 12 is set when L is odd;
  - all other bits are 0.

  Bytes 2 and 3 hold the byte count, little-endian.
- R5: The even part of the frame is written from byte 4 in arrival order. A frame with L < 64 also has its odd last byte written right after that part, and is then zero-filled up to and including byte 67.
- R6: When `crc_strip` is 0, four CRC bytes follow the data or padding, least-significant byte first.
  - The CRC uses the reflected polynomial 0xEDB88320, an all-ones start value and a final inversion.
  - It covers the frame bytes in order; a short frame is covered zero-padded to 64 bytes.
  - For an odd frame with L >= 64, the CRC comes before the last byte.
- R7: The last two bytes of the image are the control word.
  - For an odd frame with L >= 64 they are the frame's last byte, then 0x60.
  - Otherwise they are 0x00, then 0x40; short odd frames count as even here, because their padded length is 64.
- R8: After the last header write, `push` is high for exactly one cycle with `push_page` equal to the page sampled with the first byte. Every write of the frame targets that page.
- R9: `s_ready` is 0 from the cycle after the last frame byte until the push, and 1 again afterwards.
- R10: After reset, `s_ready` is 1 and `ram_we` and `push` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled with the first byte |
| soft_rst | input | 1 | Soft reset active; forces a drop |
| crc_strip | input | 1 | 1: do not store the CRC |
| page | input | PAGE_W | Target page from the allocator |
| s_start | input | 1 | Marks the first byte of a frame |
| s_valid | input | 1 | Byte valid |
| s_last | input | 1 | Marks the last byte of a frame |
| s_data | input | 8 | Frame byte |
| s_len | input | LEN_W | Frame length L in bytes (at least 1), valid with the first byte |
| s_ready | output | 1 | Packer accepts a byte |
| ram_we | output | 1 | Packet RAM write strobe |
| ram_page | output | PAGE_W | Page being written |
| ram_addr | output | log2(BUF_BYTES) | Byte offset inside the page |
| ram_wdata | output | 8 | Byte written |
| push | output | 1 | Push page onto the receive queue and raise the receive interrupt |
| push_page | output | PAGE_W | Page being pushed |

## Verification
The bench targets these boundaries:

- **Lengths 1, 63, 64 and 65.** A design that handled the odd-byte placement inconsistently would write it after the CRC, or drop it into the padding of a long frame. A design that used the raw length for the control word would emit 0x60 for short odd frames.
- **Lengths 1518 and 1519.** A wrong comparison moves the too-long status bit by one length.
- **Lengths 2038 and 2040, with and without stripping.** An off-by-one against the 2048 limit either drops a legal frame or writes past the page.

Random frames mix both strip settings and all pages, so a wrong CRC bit order or a stale page shows up as a mismatch in the CRC region or a write to the wrong page. Disabled and soft-reset frames must leave the RAM and the push output untouched.

// File: rtl/rx_frame_packer.sv
module rx_frame_packer #(
  parameter int PAGE_W    = 2,
  parameter int BUF_BYTES = 2048,
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 64,
  parameter int MAX_STD   = 1518
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_en,
  input  logic                          soft_rst,
  input  logic                          crc_strip,
  input  logic [PAGE_W-1:0]             page,
  input  logic                          s_start,
  input  logic                          s_valid,
  input  logic                          s_last,
  input  logic [7:0]                    s_data,
  input  logic [LEN_W-1:0]              s_len,
  output logic                          s_ready,
  output logic                          ram_we,
  output logic [PAGE_W-1:0]             ram_page,
  output logic [$clog2(BUF_BYTES)-1:0]  ram_addr,
  output logic [7:0]                    ram_wdata,
  output logic                          push,
  output logic [PAGE_W-1:0]             push_page
);
  localparam int ADDR_W = $clog2(BUF_BYTES);
  localparam int CNT_W  = LEN_W + 1;
  localparam logic [ADDR_W-1:0] PAD_END = ADDR_W'(MIN_FRAME + 3);

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_SKIP, S_PAD, S_CRC, S_CTRL, S_HDR, S_PUSH} st_t;

  st_t               st;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W:0]   bcount_q;
  logic [1:0]        sub;
  logic [31:0]       crc_q;
  logic [7:0]        odd_q;
  logic [PAGE_W-1:0] page_q;
  logic              strip_q, short_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire              idle      = (st == S_IDLE);
  wire [LEN_W-1:0]  len_c     = idle ? s_len : len_q;
  wire [LEN_W-1:0]  even_c    = {len_c[LEN_W-1:1], 1'b0};
  wire              short_c   = len_c < LEN_W'(MIN_FRAME);
  wire [CNT_W-1:0]  padded_c  = short_c ? CNT_W'(MIN_FRAME) : CNT_W'(even_c);
  wire [CNT_W-1:0]  count_c   = padded_c + CNT_W'(6) + (crc_strip ? CNT_W'(0) : CNT_W'(4));
  wire              accept    = rx_en && !soft_rst && (count_c <= CNT_W'(BUF_BYTES));
  wire              start_ok  = idle && s_valid && s_start && accept;
  wire              take      = start_ok || (st == S_DATA && s_valid);
  wire [LEN_W-1:0]  cnt_c     = idle ? '0 : cnt_q;
  wire              tail      = (cnt_c == even_c);
  wire              short_h   = idle ? short_c : short_q;
  wire              strip_h   = idle ? crc_strip : strip_q;
  wire              data_we   = take && !(tail && !short_h);
  wire [ADDR_W-1:0] wptr_c    = idle ? ADDR_W'(4) : wptr;
  wire [31:0]       crc_nx    = crc_step(idle ? 32'hFFFF_FFFF : crc_q, (st == S_PAD) ? 8'h00 : s_data);
  wire              long_odd  = len_q[0] && !short_q;
  wire [7:0]        stat_hi   = {3'b000, len_q[0], len_q > LEN_W'(MAX_STD), 3'b000};
  st_t              after_data;

  assign after_data = short_h ? S_PAD : (strip_h ? S_CTRL : S_CRC);
  assign s_ready    = idle || st == S_DATA || st == S_SKIP;
  assign ram_we     = data_we || st == S_PAD || st == S_CRC || st == S_CTRL || st == S_HDR;
  assign ram_addr   = (st == S_HDR) ? ADDR_W'(sub) : wptr_c;
  assign ram_page   = idle ? page : page_q;
  assign push       = (st == S_PUSH);
  assign push_page  = page_q;

  always_comb begin
    case (st)
      S_PAD:  ram_wdata = 8'h00;
      S_CRC:  ram_wdata = ~crc_q[7:0];
      S_CTRL: ram_wdata = sub[0] ? (long_odd ? 8'h60 : 8'h40) : (long_odd ? odd_q : 8'h00);
      S_HDR:
        case (sub)
          2'd0:    ram_wdata = 8'h00;
          2'd1:    ram_wdata = stat_hi;
          2'd2:    ram_wdata = bcount_q[7:0];
          default: ram_wdata = 8'(bcount_q >> 8);
        endcase
      default: ram_wdata = s_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; len_q <= '0; cnt_q <= '0; wptr <= '0; bcount_q <= '0;
      sub <= '0; crc_q <= '1; odd_q <= '0; page_q <= '0; strip_q <= 1'b0; short_q <= 1'b0;
    end else begin
      if (start_ok) begin
        len_q    <= s_len;
        page_q   <= page;
        strip_q  <= crc_strip;
        short_q  <= short_c;
        bcount_q <= count_c[ADDR_W:0];
      end
      if (take) begin
        crc_q <= crc_nx;
        cnt_q <= cnt_c + LEN_W'(1);
        wptr  <= data_we ? wptr_c + ADDR_W'(1) : wptr_c;
        if (tail) odd_q <= s_data;
        sub   <= '0;
        st    <= s_last ? after_data : S_DATA;
      end else begin
        case (st)
          S_IDLE: if (s_valid && s_start && !s_last) st <= S_SKIP;
          S_SKIP: if (s_valid && s_last) st <= S_IDLE;
          S_PAD: begin
            wptr  <= wptr + ADDR_W'(1);
            crc_q <= crc_nx;
            if (wptr == PAD_END) st <= strip_q ? S_CTRL : S_CRC;
          end
          S_CRC: begin
            wptr  <= wptr + ADDR_W'(1);
            crc_q <= {8'hFF, crc_q[31:8]};
            sub   <= sub + 2'd1;
            if (sub == 2'd3) st <= S_CTRL;
          end
          S_CTRL: begin
            wptr <= wptr + ADDR_W'(1);
            sub  <= (sub == 2'd1) ? 2'd0 : sub + 2'd1;
            if (sub == 2'd1) st <= S_HDR;
          end
          S_HDR: begin
            sub <= sub + 2'd1;
            if (sub == 2'd3) st <= S_PUSH;
          end
          S_PUSH: st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R2: no write of a stored frame lands at or beyond its byte count
  p_we_in_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !idle) |-> ({1'b0, ram_addr} < bcount_q));

  // R8: push is a single-cycle pulse
  p_push_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R8: push follows the last header byte
  p_push_after_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($past(ram_we) && $past(ram_addr) == ADDR_W'(3)));

  // R1: a frame starting while disabled writes nothing
  p_drop_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && s_valid && s_start && (!rx_en || soft_rst)) |=> (!ram_we && !push));
endmodule

// File: tb/rx_frame_packer_bench.sv
module rx_frame_packer_bench;
  localparam int CLK_P = 10;
  localparam int BUFB  = 2048;

  logic clk = 0, rst_n = 0;
  logic rx_en = 1, soft_rst = 0, crc_strip = 0;
  logic [1:0] page = 0;
  logic s_start = 0, s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic [15:0] s_len = 0;
  logic s_ready, ram_we, push;
  logic [1:0] ram_page, push_page;
  logic [10:0] ram_addr;
  logic [7:0] ram_wdata;

  rx_frame_packer u_rx_frame_packer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst), .crc_strip(crc_strip),
    .page(page), .s_start(s_start), .s_valid(s_valid), .s_last(s_last), .s_data(s_data),
    .s_len(s_len), .s_ready(s_ready), .ram_we(ram_we), .ram_page(ram_page),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .push(push), .push_page(push_page));

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0, wr_cnt = 0, push_cnt = 0, pg_bad = 0;
  bit done_flag = 0;
  logic [1:0] exp_page, got_push_page;
  logic [7:0] mem [BUFB];
  logic [7:0] frame [BUFB+16];
  logic [7:0] expm [BUFB+16];

  always @(negedge clk) if (rst_n) begin
    if (ram_we) begin
      mem[ram_addr] = ram_wdata;
      wr_cnt++;
      if (ram_page != exp_page) pg_bad++;
    end
    if (push) begin push_cnt++; got_push_page = push_page; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int j = 0; j < 8; j++) begin
      if ((r[0] ^ b[0]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320; else r = r >> 1;
      b = b >> 1;
    end
    return r;
  endfunction

  task automatic cmp_region(input int lo, input int hi, input string req);
    int bad = -1;
    for (int a = lo; a < hi; a++) if (bad < 0 && mem[a] !== expm[a]) bad = a;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, $sformatf("%s byte %0d", req, bad), int'(mem[bad]), int'(expm[bad]));
  endtask

  task automatic run_frame(input int L, input bit strip, input bit en, input bit srst,
                           input logic [1:0] pg);
    int even = L & ~1;
    bit shrt = L < 64;
    int padded = shrt ? 64 : even;
    int cnt = padded + 6 + (strip ? 0 : 4);
    bit drop = !en || srst || cnt > 2048;
    int p;
    logic [31:0] crc;
    for (int a = 0; a < BUFB; a++) mem[a] = 8'hEE;
    for (int i = 0; i < L; i++) frame[i] = 8'($urandom);
    for (int i = 0; i < BUFB + 16; i++) expm[i] = 8'hEE;
    expm[0] = 8'h00;
    expm[1] = {3'b000, L[0], L > 1518, 3'b000};
    expm[2] = cnt[7:0];
    expm[3] = cnt[15:8];
    for (int i = 0; i < even; i++) expm[4+i] = frame[i];
    if (shrt) begin
      if (L[0]) expm[4+even] = frame[L-1];
      for (int i = L; i < 64; i++) expm[4+i] = 8'h00;
    end
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < (shrt ? 64 : L); i++) crc = crc_upd(crc, (i < L) ? frame[i] : 8'h00);
    crc = ~crc;
    p = 4 + padded;
    if (!strip) begin
      for (int k = 0; k < 4; k++) expm[p+k] = crc[8*k +: 8];
      p += 4;
    end
    if (L[0] && !shrt) begin expm[p] = frame[L-1]; expm[p+1] = 8'h60; end
    else begin expm[p] = 8'h00; expm[p+1] = 8'h40; end

    wr_cnt = 0; push_cnt = 0; pg_bad = 0; exp_page = pg;
    @(posedge clk); #1;
    rx_en = en; soft_rst = srst; crc_strip = strip; page = pg;
    for (int i = 0; i < L; i++) begin
      s_valid = 1; s_start = (i == 0); s_last = (i == L-1); s_data = frame[i];
      s_len = (i == 0) ? 16'(L) : 16'hxxxx;
      @(posedge clk); #1;
    end
    s_valid = 0; s_start = 0; s_last = 0; page = ~pg;
    @(negedge clk);
    if (drop) begin
      repeat (30) @(negedge clk);
      chk(wr_cnt == 0 && push_cnt == 0 && s_ready, (cnt > 2048 && en && !srst) ? "R3 oversize drop" : "R1 disabled drop",
          wr_cnt + push_cnt, 0);
    end else begin
      chk(s_ready == 1'b0, "R9 ready low while packing", int'(s_ready), 0);
      for (int k = 0; k < 3000 && push_cnt == 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(push_cnt == 1 && got_push_page == pg && pg_bad == 0, "R8 push and page", push_cnt, 1);
      chk(s_ready == 1'b1, "R9 ready after push", int'(s_ready), 1);
      chk(wr_cnt == cnt, "R2 write count", wr_cnt, cnt);
      cmp_region(0, 4, "R4 header");
      cmp_region(4, 4 + padded, "R5 data and pad");
      if (!strip) cmp_region(4 + padded, 8 + padded, "R6 crc");
      cmp_region(p, p + 2, "R7 control");
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    chk(0, "watchdog", 0, 1);
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_ready && !ram_we && !push, "R10 reset state", {s_ready, ram_we, push}, 3'b100);
    #1 rst_n = 1;
    run_frame(1, 0, 1, 0, 2'd1);
    run_frame(63, 0, 1, 0, 2'd2);
    run_frame(64, 0, 1, 0, 2'd3);
    run_frame(65, 0, 1, 0, 2'd0);
    run_frame(65, 1, 1, 0, 2'd1);
    run_frame(62, 1, 1, 0, 2'd2);
    run_frame(1518, 0, 1, 0, 2'd3);
    run_frame(1519, 0, 1, 0, 2'd0);
    run_frame(2038, 0, 1, 0, 2'd1);
    run_frame(2040, 0, 1, 0, 2'd2);
    run_frame(2040, 1, 1, 0, 2'd2);
    run_frame(100, 0, 0, 0, 2'd3);
    run_frame(100, 0, 1, 1, 2'd3);
    run_frame(1, 0, 0, 0, 2'd0);
    for (int n = 0; n < 30; n++)
      run_frame(1 + int'($urandom % 300), 1'($urandom), 1, 0, 2'($urandom));
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end
endmodule